// File: doc/BRIEF.md
# Instruction Cycle Control Sequencer

This block is the control sequencer and register set of a small accumulator machine. It walks each instruction through a fetch subcycle, an optional indirect subcycle, an execute subcycle and, when enabled and requested, an interrupt subcycle. All memory traffic goes through one request/ready port. The port is fed from an address register and a buffer register, and both are held stable for the whole access.

The machine word is 16 bits. It holds a 4-bit opcode in bits 15:12, an indirect flag in bit 11 and an 11-bit address field in bits 10:0. The block holds the program counter, the instruction register and the accumulator. It executes load, store, add, jump, enable-interrupt and halt; every other opcode does nothing. When an interrupt is taken, the return address goes to memory location 0. The interrupt-enable flag is then cleared and execution resumes at address 1, where the handler lives.

Top module: `icyc_seq`

## Requirements
- R1: While reset is low, mem_req, int_en and halted are 0. After reset is released, the first memory access is a read of address 0.
- R2: Each instruction begins with a read at the program counter. The program counter advances by one (modulo 2048) as that read completes, so instructions without a jump run from consecutive addresses.
- R3: Opcode 0 (LOAD) reads the effective address into the accumulator. Opcode 1 (STORE) writes the accumulator to the effective address. Without indirection, the effective address is bits 10:0 of the instruction.
- R4: Opcode 2 (ADD) reads the effective address and adds the word to the accumulator modulo 2^16.
- R5: When bit 11 is set, for any opcode, one extra read of the address field follows the fetch. Bits 10:0 of the returned word then become the effective address.
- R6: Opcode 3 (JMP) makes the effective address the next fetch address and makes no data access.
- R7: Opcode 4 (EI) sets int_en. Opcodes 5 to 14 leave the accumulator and memory untouched, and the next fetch is sequential.
- R8: If int_en is 1 and irq is 1 when an instruction other than HALT finishes, the block writes the program counter (zero-extended) to address 0. It then clears int_en and fetches next from address 1. With int_en at 0, irq has no effect.
- R9: mem_req stays high with stable mem_addr, mem_we and mem_wdata until mem_ready is high at a clock edge. Read data is taken on that edge. mem_we is only high together with mem_req.
- R10: Opcode 15 (HALT) raises halted and stops all memory requests until reset.
- R11: The interrupt check uses the enable value held before the finishing instruction acted. An interrupt pending when EI executes is therefore taken only after the next instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 11 | Access address (address register) |
| mem_wdata | output | 16 | Write data (buffer register) |
| mem_rdata | input | 16 | Read data, valid while mem_ready is high |
| mem_ready | input | 1 | Access completes at this clock edge |
| irq | input | 1 | Interrupt request level |
| int_en | output | 1 | Interrupt-enable flag |
| halted | output | 1 | Sequencer parked after HALT |

## Verification
Every result of this block shows up as a memory access, and the bench checks each one in the cycle its address, direction and data are presented. That cycle comes one clock after the register transfer that set the address register: after the fetch, after the indirect step, after the execute dispatch or after the save step. The comparison is made at the falling edge on which the bench raises mem_ready, and the data then completes at the next rising edge. An instruction-level model in the bench predicts the ordered access list, so stretching the wait by zero to three cycles does not move any expected value. halted rises one cycle after the dispatch of HALT, and the bench samples it only after a twelve-cycle settling window.

// File: rtl/icyc_pkg.sv
package icyc_pkg;

    localparam int unsigned OP_W = 4;

    localparam logic [OP_W-1:0] OPC_LOAD  = 4'd0;
    localparam logic [OP_W-1:0] OPC_STORE = 4'd1;
    localparam logic [OP_W-1:0] OPC_ADD   = 4'd2;
    localparam logic [OP_W-1:0] OPC_JMP   = 4'd3;
    localparam logic [OP_W-1:0] OPC_EI    = 4'd4;
    localparam logic [OP_W-1:0] OPC_HALT  = 4'd15;

    typedef enum logic [3:0] {
        ST_F_MAR,   // PC -> MAR
        ST_F_RD,    // fetch read, PC+1 on completion
        ST_F_IR,    // MBR -> IR
        ST_DEC,     // examine IR
        ST_I_MAR,   // address field -> MAR
        ST_I_RD,    // indirect read
        ST_X_DISP,  // execute dispatch
        ST_X_RD,    // operand read
        ST_X_WR,    // operand write
        ST_T_SAVE,  // PC -> MBR, save address -> MAR
        ST_T_WR,    // save write, then vector
        ST_HALT
    } cyc_state_e;

endpackage

// File: rtl/icyc_decode.sv
module icyc_decode
    import icyc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 11
) (
    input  logic [DATA_W-1:0] word_i,
    output logic              indirect_o,
    output logic [ADDR_W-1:0] field_o,
    output logic              rd_o,
    output logic              add_o,
    output logic              st_o,
    output logic              jmp_o,
    output logic              ei_o,
    output logic              halt_o
);
    localparam int IND_BIT = DATA_W - OP_W - 1;

    logic [OP_W-1:0] opcode;

    always_comb begin
        opcode     = word_i[DATA_W-1 -: OP_W];
        indirect_o = word_i[IND_BIT];
        field_o    = word_i[ADDR_W-1:0];
        add_o      = (opcode == OPC_ADD);
        rd_o       = (opcode == OPC_LOAD) || add_o;
        st_o       = (opcode == OPC_STORE);
        jmp_o      = (opcode == OPC_JMP);
        ei_o       = (opcode == OPC_EI);
        halt_o     = (opcode == OPC_HALT);
    end

endmodule

// File: rtl/icyc_acc_alu.sv
module icyc_acc_alu #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic              add_i,
    output logic [DATA_W-1:0] result_o
);
    always_comb begin
        result_o = add_i ? (acc_i + operand_i) : operand_i;
    end
endmodule

// File: rtl/icyc_seq.sv
module icyc_seq
    import icyc_pkg::*;
#(
    parameter int                DATA_W    = 16,
    parameter int                ADDR_W    = 11,
    parameter logic [ADDR_W-1:0] SAVE_ADDR = '0,
    parameter logic [ADDR_W-1:0] VEC_ADDR  = 11'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    input  logic              irq,
    output logic              int_en,
    output logic              halted
);
    localparam int PAD_W = DATA_W - ADDR_W;

    typedef struct packed {
        cyc_state_e        state;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] mar;
        logic [DATA_W-1:0] mbr;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] acc;
        logic              ie;
    } seq_regs_t;

    seq_regs_t q, d;

    logic              ir_ind, dc_rd, dc_add, dc_st, dc_jmp, dc_ei, dc_halt;
    logic [ADDR_W-1:0] ir_field;
    logic [DATA_W-1:0] alu_res;
    logic [ADDR_W-1:0] eff_addr;
    cyc_state_e        after_exec;

    icyc_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dec_i (
        .word_i     (q.ir),
        .indirect_o (ir_ind),
        .field_o    (ir_field),
        .rd_o       (dc_rd),
        .add_o      (dc_add),
        .st_o       (dc_st),
        .jmp_o      (dc_jmp),
        .ei_o       (dc_ei),
        .halt_o     (dc_halt)
    );

    icyc_acc_alu #(.DATA_W(DATA_W)) alu_i (
        .acc_i     (q.acc),
        .operand_i (mem_rdata),
        .add_i     (dc_add),
        .result_o  (alu_res)
    );

    always_comb begin
        d          = q;
        eff_addr   = q.mbr[ADDR_W-1:0];
        after_exec = (q.ie && irq) ? ST_T_SAVE : ST_F_MAR;
        unique case (q.state)
            ST_F_MAR: begin
                d.mar   = q.pc;
                d.state = ST_F_RD;
            end
            ST_F_RD: begin
                if (mem_ready) begin
                    d.mbr   = mem_rdata;
                    d.pc    = q.pc + ADDR_W'(1);
                    d.state = ST_F_IR;
                end
            end
            ST_F_IR: begin
                d.ir    = q.mbr;
                d.state = ST_DEC;
            end
            ST_DEC: begin
                d.state = ir_ind ? ST_I_MAR : ST_X_DISP;
            end
            ST_I_MAR: begin
                d.mar   = ir_field;
                d.state = ST_I_RD;
            end
            ST_I_RD: begin
                if (mem_ready) begin
                    d.mbr   = mem_rdata;
                    d.state = ST_X_DISP;
                end
            end
            ST_X_DISP: begin
                if (dc_halt) begin
                    d.state = ST_HALT;
                end else if (dc_rd) begin
                    d.mar   = eff_addr;
                    d.state = ST_X_RD;
                end else if (dc_st) begin
                    d.mar   = eff_addr;
                    d.mbr   = q.acc;
                    d.state = ST_X_WR;
                end else begin
                    if (dc_jmp) d.pc = eff_addr;
                    if (dc_ei)  d.ie = 1'b1;
                    d.state = after_exec;
                end
            end
            ST_X_RD: begin
                if (mem_ready) begin
                    d.mbr   = mem_rdata;
                    d.acc   = alu_res;
                    d.state = after_exec;
                end
            end
            ST_X_WR: begin
                if (mem_ready) d.state = after_exec;
            end
            ST_T_SAVE: begin
                d.mbr   = {{PAD_W{1'b0}}, q.pc};
                d.mar   = SAVE_ADDR;
                d.ie    = 1'b0;
                d.state = ST_T_WR;
            end
            ST_T_WR: begin
                if (mem_ready) begin
                    d.pc    = VEC_ADDR;
                    d.state = ST_F_MAR;
                end
            end
            ST_HALT: begin
                d.state = ST_HALT;
            end
            default: begin
                d.state = ST_HALT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_F_MAR;
            q.pc    <= '0;
            q.mar   <= '0;
            q.mbr   <= '0;
            q.ir    <= '0;
            q.acc   <= '0;
            q.ie    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        mem_req   = (q.state == ST_F_RD) || (q.state == ST_I_RD) || (q.state == ST_X_RD)
                 || (q.state == ST_X_WR) || (q.state == ST_T_WR);
        mem_we    = (q.state == ST_X_WR) || (q.state == ST_T_WR);
        mem_addr  = q.mar;
        mem_wdata = q.mbr;
        int_en    = q.ie;
        halted    = (q.state == ST_HALT);
    end

    // R9: a pending access keeps its request, address, direction and data
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                     && $stable(mem_wdata)));

    assert_we_with_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    // R2: the completed fetch read steps the program counter by one
    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_F_RD && mem_ready) |=> (q.pc == $past(q.pc) + ADDR_W'(1)));

    // R8: the enable drops only as the return-address save write is presented
    assert_save_on_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_en) |-> (mem_req && mem_we && mem_addr == SAVE_ADDR));

    // R10: once parked, the sequencer stays parked and silent
    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !mem_req));

    // R7: the instruction register decodes to at most one class
    assert_one_class_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dc_rd, dc_st, dc_jmp, dc_ei, dc_halt}));

endmodule

// File: tb/icyc_seq_tb_top.sv
module icyc_seq_tb_top;
    localparam int DW   = 16;
    localparam int AW   = 11;
    localparam int MEMN = 2048;
    localparam int MAXA = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mem_req, mem_we, int_en, halted;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_ready = 1'b0;
    logic          irq = 1'b0;

    always #10 clk = ~clk;

    icyc_seq dut_i (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .irq(irq), .int_en(int_en), .halted(halted)
    );

    logic [DW-1:0] bmem [MEMN];
    logic [DW-1:0] mmem [MEMN];
    logic [AW-1:0] ex_addr [MAXA];
    logic          ex_we   [MAXA];
    logic [DW-1:0] ex_data [MAXA];
    int    ex_n;
    bit    ex_halt, ex_ie;
    int    seen;
    bit    mon_on;
    string acc_tag = "R2";
    int    compared = 0, mismatched = 0, cyc = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] ins(input int op, input bit ind, input int a);
        return {4'(op), ind, 11'(a)};
    endfunction

    task automatic push(input logic [AW-1:0] a, input logic we, input logic [DW-1:0] dv);
        ex_addr[ex_n] = a; ex_we[ex_n] = we; ex_data[ex_n] = dv; ex_n++;
    endtask

    // instruction-level reference: predicts the ordered memory accesses
    task automatic model_run(input bit irq_lv);
        logic [AW-1:0] pc = '0;
        logic [AW-1:0] ea;
        logic [DW-1:0] acc = '0;
        logic [DW-1:0] w;
        bit ie = 0;
        bit ieb;
        ex_n = 0; ex_halt = 0;
        for (int i = 0; i < MEMN; i++) mmem[i] = bmem[i];
        while (!ex_halt && ex_n < MAXA - 8) begin
            w = mmem[pc]; push(pc, 1'b0, '0); pc = pc + 11'd1;
            ea = w[AW-1:0];
            if (w[11]) begin push(ea, 1'b0, '0); ea = mmem[ea][AW-1:0]; end
            ieb = ie;
            case (w[15:12])
                4'd0:  begin push(ea, 1'b0, '0); acc = mmem[ea]; end
                4'd1:  begin push(ea, 1'b1, acc); mmem[ea] = acc; end
                4'd2:  begin push(ea, 1'b0, '0); acc = acc + mmem[ea]; end
                4'd3:  pc = ea;
                4'd4:  ie = 1;
                4'd15: ex_halt = 1;
                default: ;
            endcase
            if (!ex_halt && ieb && irq_lv) begin
                push(11'd0, 1'b1, {5'b0, pc}); mmem[0] = {5'b0, pc}; pc = 11'd1; ie = 0;
            end
        end
        ex_ie = ie;
    endtask

    // memory responder and access monitor, acting on falling edges
    int            wait_left = 0;
    bit            in_acc = 0;
    logic [AW-1:0] h_addr;
    logic          h_we;
    logic [DW-1:0] h_wd;

    task automatic complete_access();
        if (mon_on) begin
            if (seen < ex_n)
                chk(mem_addr == ex_addr[seen] && mem_we == ex_we[seen]
                    && (!mem_we || mem_wdata == ex_data[seen]), acc_tag, "access",
                    {mem_we, mem_addr, mem_wdata},
                    {ex_we[seen], ex_addr[seen], ex_we[seen] ? ex_data[seen] : mem_wdata});
            else if (ex_halt)
                chk(0, "R10", "access after halt", {mem_we, mem_addr}, 0);
        end
        seen++;
        if (mem_we) bmem[mem_addr] = mem_wdata;
        else mem_rdata = bmem[mem_addr];
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ready = 1'b0; in_acc = 0;
        end else if (mem_ready) begin
            mem_ready = 1'b0;
        end else if (mem_req) begin
            if (in_acc) begin
                if (mem_addr != h_addr || mem_we != h_we || mem_wdata != h_wd)
                    chk(0, "R9", "access changed while waiting",
                        {mem_we, mem_addr, mem_wdata}, {h_we, h_addr, h_wd});
            end else begin
                in_acc = 1; h_addr = mem_addr; h_we = mem_we; h_wd = mem_wdata;
                wait_left = int'($urandom % 4);
            end
            if (wait_left == 0) begin
                complete_access(); mem_ready = 1'b1; in_acc = 0;
            end else begin
                wait_left--;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            compared++; mismatched++;
            $display("FAIL R10 watchdog: actual %0d expected 0", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic run_prog(input bit irq_lv, input string tag);
        int t;
        model_run(irq_lv);
        acc_tag = tag;
        irq = irq_lv;
        rst_n = 1'b0;
        mon_on = 1; seen = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!mem_req && !int_en && !halted, "R1", "reset outputs",
            {mem_req, int_en, halted}, 0);
        rst_n = 1'b1;
        t = 0;
        while (seen < ex_n && t < 20000) begin @(negedge clk); t++; end
        if (seen < ex_n) chk(0, tag, "accesses stalled", seen, ex_n);
        if (ex_halt) begin
            repeat (12) @(negedge clk);
            chk(halted, "R10", "halted", halted, 1);
            chk(seen == ex_n, "R10", "access count", seen, ex_n);
            chk(int_en == ex_ie, "R11", "final int_en", int_en, ex_ie);
        end
        mon_on = 0;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < MEMN; i++) bmem[i] = 16'hF000;
    endtask

    initial begin
        void'($urandom(32'd20117));
        mon_on = 0;

        // R1 R3 R4: load, add with wrap, store
        clear_mem();
        bmem[0] = ins(0, 0, 20); bmem[1] = ins(2, 0, 21); bmem[2] = ins(1, 0, 22);
        bmem[3] = ins(2, 0, 22); bmem[4] = ins(1, 0, 23); bmem[5] = ins(15, 0, 0);
        bmem[20] = 16'hFFF0; bmem[21] = 16'h0025;
        run_prog(0, "R3");
        chk(bmem[22] == 16'h0015, "R4", "wrapped sum", bmem[22], 16'h0015);
        chk(bmem[23] == 16'h002A, "R4", "doubled sum", bmem[23], 16'h002A);

        // R5 R6: indirect load, store and jump
        clear_mem();
        bmem[0] = ins(0, 1, 30); bmem[1] = ins(1, 1, 31); bmem[2] = ins(3, 1, 32);
        bmem[30] = 16'hF040; bmem[31] = 16'h0050; bmem[32] = 16'h0010;
        bmem[16'h40] = 16'h1234; bmem[16'h10] = ins(15, 0, 0);
        run_prog(0, "R5");
        chk(bmem[16'h50] == 16'h1234, "R5", "indirect store", bmem[16'h50], 16'h1234);

        // R8 R11: EI, pending request taken after the following instruction
        clear_mem();
        bmem[0] = ins(3, 0, 8); bmem[8] = ins(4, 0, 0); bmem[9] = ins(0, 0, 40);
        bmem[10] = ins(15, 0, 0); bmem[1] = ins(1, 0, 41); bmem[2] = ins(15, 0, 0);
        bmem[40] = 16'h0ABC;
        run_prog(1, "R8");
        chk(bmem[0] == 16'h000A, "R11", "saved return address", bmem[0], 16'h000A);
        chk(bmem[41] == 16'h0ABC, "R8", "handler store", bmem[41], 16'h0ABC);
        chk(int_en == 1'b0, "R8", "enable cleared", int_en, 0);

        // R8: request ignored while disabled
        clear_mem();
        bmem[0] = ins(0, 0, 40); bmem[1] = ins(1, 0, 41); bmem[2] = ins(15, 0, 0);
        bmem[40] = 16'h7777;
        run_prog(1, "R8");
        chk(bmem[0] == 16'h0028, "R8", "no save write", bmem[0], 16'h0028);
        chk(bmem[41] == 16'h7777, "R8", "sequential store", bmem[41], 16'h7777);

        // R7: unlisted opcodes, with and without indirection
        clear_mem();
        bmem[0] = ins(0, 0, 40); bmem[1] = ins(7, 0, 41); bmem[2] = ins(12, 1, 42);
        bmem[3] = ins(1, 0, 43); bmem[4] = ins(15, 0, 0);
        bmem[40] = 16'h5A5A; bmem[42] = 16'h0044;
        run_prog(0, "R7");
        chk(bmem[43] == 16'h5A5A, "R7", "accumulator kept", bmem[43], 16'h5A5A);

        // R2: random programs against the reference model
        for (int p = 0; p < 60; p++) begin
            for (int i = 0; i < MEMN; i++) begin
                int s;
                logic [3:0] op;
                s = int'($urandom % 8);
                if (s < 5) op = 4'(s);
                else if (s == 5) op = 4'd15;
                else op = 4'(5 + $urandom % 10);
                bmem[i] = {op, ($urandom % 4 == 0), 11'($urandom % 64)};
            end
            run_prog(($urandom % 2) == 1, "R2");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule